// File: doc/BRIEF.md
# Insertion-Point Scan Configuration Controller

This block loads a long row of test flip-flops through a serial scan path so that exactly one position in the row is marked. A requester presents a zero-based position index and a fill value, then pulses a start input while the controller is ready. The controller sends one bit per clock with scan enable high. The marked position receives the inverse of the fill value. Every other position receives the fill value itself.

Positions are counted from the right-hand end of the row. Index 0 is the rightmost flip-flop, and larger indices move toward the left. The stream therefore begins with the bit for the leftmost position and ends with the bit for position 0. A companion output holds the row's clock gating open for the whole transfer. The row has 264 flip-flops (2^8 plus 8), so indices are 9 bits wide, and any index past the end of the row is pulled back to the last position.

Top module: `cfg_scan_ctrl`

## Requirements
- R1: After synchronous reset, `ready` is 1, and `scan_en`, `gate_bypass` and `scan_bit` are 0.
- R2: Each accepted start produces exactly ROW_LEN (264) consecutive cycles with `scan_en` high, so exactly 264 bits are shifted.
- R3: The bit for position ROW_LEN-1 (leftmost) is sent first and the bit for position 0 (rightmost) is sent last. In a row that shifts from right to left, index k therefore ends up k places from the right-hand end.
- R4: After one transfer, the selected position holds the inverse of the captured fill value and every other position holds the fill value.
- R5: An index of ROW_LEN (264) or more is treated as ROW_LEN-1 (263).
- R6: A start seen while `ready` is 1 is accepted. On the next cycle `ready` is 0 and `scan_en` is 1.
- R7: `ready` returns to 1 on the cycle after the last bit is shifted, so it stays low for exactly ROW_LEN cycles.
- R8: A start pulse, index change or fill change while busy has no effect on the transfer in progress.
- R9: `gate_bypass` equals `scan_en` at all times, and `ready` and `scan_en` are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the controller and the row |
| rst | input | 1 | Synchronous active-high reset |
| cfg_start | input | 1 | Request a transfer; accepted only while ready |
| ins_point | input | 9 | Zero-based position to mark, counted from the right |
| dummy_bit | input | 1 | Fill value for positions that are not selected |
| ready | output | 1 | High when idle and able to accept a start |
| scan_en | output | 1 | Scan enable for the row; high while bits are shifted |
| gate_bypass | output | 1 | Holds the row's clock gating open during a transfer |
| scan_bit | output | 1 | Serial data into the row |

## Verification
The assertions assume that `cfg_start` is sampled only on clock edges and that `ins_point` and `dummy_bit` are stable at the edge where a start is accepted. The bench drives all inputs on the falling edge, so each value is settled before the rising edge that samples it.

The sweep covers every legal index, alternating the fill value. It also sends indices past the end of the row. During two of the transfers, it disturbs the start, index and fill inputs partway through, which exercises the rule that inputs are ignored while busy.

// File: rtl/cfg_scan_pkg.sv
package cfg_scan_pkg;

    localparam int DEF_ROW_LEN = 264;
    localparam int DEF_IDX_W   = 9;

    typedef enum logic {
        SEQ_IDLE  = 1'b0,
        SEQ_SHIFT = 1'b1
    } seq_state_e;

    // value presented for one row position
    function automatic logic mark_value(input logic hit, input logic fill);
        return hit ? ~fill : fill;
    endfunction

endpackage

// File: rtl/cfg_scan_capture.sv
module cfg_scan_capture #(
    parameter int ROW_LEN = cfg_scan_pkg::DEF_ROW_LEN,
    parameter int IDX_W   = cfg_scan_pkg::DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [IDX_W-1:0] ins_point,
    input  logic             dummy_bit,
    output logic [IDX_W-1:0] sel_idx,
    output logic             fill_val
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ROW_LEN - 1);

    logic [IDX_W-1:0] clamped;

    // out-of-range requests land on the leftmost position
    always_comb begin
        if (ins_point > LAST_IDX) clamped = LAST_IDX;
        else                      clamped = ins_point;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_idx  <= '0;
            fill_val <= 1'b0;
        end else if (accept) begin
            sel_idx  <= clamped;
            fill_val <= dummy_bit;
        end
    end

    a_r5_index_in_row: assert property (@(posedge clk) disable iff (rst)
        accept |=> (sel_idx <= LAST_IDX));

    a_r8_hold_when_idle_req: assert property (@(posedge clk) disable iff (rst)
        !accept |=> ($stable(sel_idx) && $stable(fill_val)));

endmodule

// File: rtl/cfg_scan_seq.sv
module cfg_scan_seq #(
    parameter int ROW_LEN = cfg_scan_pkg::DEF_ROW_LEN,
    parameter int IDX_W   = cfg_scan_pkg::DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start_req,
    output logic             accept,
    output logic             busy,
    output logic             idle,
    output logic [IDX_W-1:0] pos
);
    import cfg_scan_pkg::*;

    localparam logic [IDX_W-1:0] FIRST_POS = IDX_W'(ROW_LEN - 1);

    seq_state_e state;

    assign idle   = (state == SEQ_IDLE);
    assign busy   = (state == SEQ_SHIFT);
    assign accept = idle && start_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEQ_IDLE;
            pos   <= '0;
        end else begin
            unique case (state)
                SEQ_IDLE: begin
                    if (start_req) begin
                        state <= SEQ_SHIFT;
                        pos   <= FIRST_POS;
                    end
                end
                SEQ_SHIFT: begin
                    if (pos == '0) state <= SEQ_IDLE;
                    else           pos   <= pos - 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    a_r6_accept_goes_busy: assert property (@(posedge clk) disable iff (rst)
        accept |=> (busy && !idle && pos == FIRST_POS));

    a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
        (busy && pos != '0) |=> (busy && pos == $past(pos) - 1'b1));

    a_r7_ready_after_last: assert property (@(posedge clk) disable iff (rst)
        (busy && pos == '0) |=> idle);

    a_r3_leftmost_first: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (pos == FIRST_POS));

endmodule

// File: rtl/cfg_scan_bitgen.sv
module cfg_scan_bitgen #(
    parameter int IDX_W = cfg_scan_pkg::DEF_IDX_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [IDX_W-1:0] pos,
    input  logic [IDX_W-1:0] sel_idx,
    input  logic             fill_val,
    output logic             scan_bit
);
    import cfg_scan_pkg::*;

    always_comb begin
        if (active) scan_bit = mark_value(pos == sel_idx, fill_val);
        else        scan_bit = 1'b0;
    end

    a_r4_fill_elsewhere: assert property (@(posedge clk) disable iff (rst)
        (active && pos != sel_idx) |-> (scan_bit == fill_val));

    a_r4_marker_inverted: assert property (@(posedge clk) disable iff (rst)
        (active && pos == sel_idx) |-> (scan_bit != fill_val));

endmodule

// File: rtl/cfg_scan_ctrl.sv
module cfg_scan_ctrl #(
    parameter int ROW_LEN = cfg_scan_pkg::DEF_ROW_LEN,
    parameter int IDX_W   = $clog2(ROW_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_start,
    input  logic [IDX_W-1:0] ins_point,
    input  logic             dummy_bit,
    output logic             ready,
    output logic             scan_en,
    output logic             gate_bypass,
    output logic             scan_bit
);
    logic             accept;
    logic             busy;
    logic             idle;
    logic [IDX_W-1:0] pos;
    logic [IDX_W-1:0] sel_idx;
    logic             fill_val;

    cfg_scan_seq #(.ROW_LEN(ROW_LEN), .IDX_W(IDX_W)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start_req (cfg_start),
        .accept    (accept),
        .busy      (busy),
        .idle      (idle),
        .pos       (pos)
    );

    cfg_scan_capture #(.ROW_LEN(ROW_LEN), .IDX_W(IDX_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .accept    (accept),
        .ins_point (ins_point),
        .dummy_bit (dummy_bit),
        .sel_idx   (sel_idx),
        .fill_val  (fill_val)
    );

    cfg_scan_bitgen #(.IDX_W(IDX_W)) u_bits (
        .clk      (clk),
        .rst      (rst),
        .active   (busy),
        .pos      (pos),
        .sel_idx  (sel_idx),
        .fill_val (fill_val),
        .scan_bit (scan_bit)
    );

    assign ready       = idle;
    assign scan_en     = busy;
    assign gate_bypass = busy;

    a_r9_ready_excl_enable: assert property (@(posedge clk) disable iff (rst)
        !(ready && scan_en));

    a_r9_bypass_tracks_enable: assert property (@(posedge clk) disable iff (rst)
        gate_bypass == scan_en);

    a_r1_reset_idle: assert property (@(posedge clk)
        $past(rst) |-> (ready && !scan_en && !scan_bit));

endmodule

// File: tb/sim_cfg_scan_ctrl.sv
module sim_cfg_scan_ctrl;
    localparam int ROW_LEN  = 264;
    localparam int IDX_W    = 9;
    localparam time CLK_PER = 10ns;

    logic             clk = 1'b0;
    logic             rst;
    logic             cfg_start;
    logic [IDX_W-1:0] ins_point;
    logic             dummy_bit;
    logic             ready, scan_en, gate_bypass, scan_bit;

    int total = 0;
    int bad   = 0;
    int shifts;
    bit done  = 0;
    logic [ROW_LEN-1:0] row;

    always #(CLK_PER/2) clk = ~clk;

    cfg_scan_ctrl #(.ROW_LEN(ROW_LEN), .IDX_W(IDX_W)) u0 (
        .clk(clk), .rst(rst), .cfg_start(cfg_start), .ins_point(ins_point),
        .dummy_bit(dummy_bit), .ready(ready), .scan_en(scan_en),
        .gate_bypass(gate_bypass), .scan_bit(scan_bit)
    );

    // row model: enters at the right end, moves left
    always @(posedge clk) begin
        if (scan_en) begin
            row    <= {row[ROW_LEN-2:0], scan_bit};
            shifts <= shifts + 1;
        end
        if (!done && scan_en !== gate_bypass) begin
            total++; bad++;
            $display("FAIL R9 gate_bypass=%b scan_en=%b", gate_bypass, scan_en);
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cfg(input int idx, input logic fill, input bit disturb);
        int eff;
        int low;
        logic [ROW_LEN-1:0] exp_row;
        eff = (idx >= ROW_LEN) ? ROW_LEN - 1 : idx;
        for (int k = 0; k < ROW_LEN; k++) exp_row[k] = (k == eff) ? ~fill : fill;
        shifts = 0;
        cfg_start = 1'b1; ins_point = IDX_W'(idx); dummy_bit = fill;
        @(negedge clk);
        cfg_start = 1'b0;
        check("R6 ready low after start", 64'(ready), 64'd0);
        check("R6 scan_en high after start", 64'(scan_en), 64'd1);
        low = 0;
        while (!ready && low < 1000) begin
            low++;
            if (disturb && low == 10) begin
                cfg_start = 1'b1; ins_point = IDX_W'((eff + 7) % ROW_LEN); dummy_bit = ~fill;
            end
            if (disturb && low == 11) cfg_start = 1'b0;
            @(negedge clk);
        end
        check("R7 ready low cycles", 64'(low), 64'(ROW_LEN));
        check("R2 bits shifted", 64'(shifts), 64'(ROW_LEN));
        check("R9 idle scan_en", 64'(scan_en), 64'd0);
        total++;
        if (row !== exp_row) begin
            bad++;
            $display("FAIL %s idx=%0d actual=%h expected=%h",
                     disturb ? "R8" : ((idx >= ROW_LEN) ? "R5" : "R3/R4"), idx, row, exp_row);
        end
        @(negedge clk);
    endtask

    initial begin
        rst = 1'b1; cfg_start = 1'b0; ins_point = '0; dummy_bit = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 ready", 64'(ready), 64'd1);
        check("R1 scan_en", 64'(scan_en), 64'd0);
        check("R1 gate_bypass", 64'(gate_bypass), 64'd0);
        check("R1 scan_bit", 64'(scan_bit), 64'd0);
        // R3 R4: every legal index, fill alternating
        for (int i = 0; i < ROW_LEN; i++) run_cfg(i, logic'(i[0]), 1'b0);
        // R5 clamp
        run_cfg(264, 1'b0, 1'b0);
        run_cfg(400, 1'b1, 1'b0);
        run_cfg(511, 1'b0, 1'b0);
        // R8 disturbance while busy
        run_cfg(5, 1'b0, 1'b1);
        run_cfg(200, 1'b1, 1'b1);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule